// File: doc/BRIEF.md
# I2C Register-Access Slave with Pointer Auto-Increment

This block is the serial front end of a register bank. It watches an I2C bus on two plain input lines, sampled by the system clock through a two-flop synchronizer, and gives a bus master read and write access to a register file of 128 entries of 8 bits. The register file itself sits outside the block. The block reaches it through a simple port: a 7-bit address, write data, a one-cycle write strobe and a one-cycle read strobe, with read data returned combinationally for the current address.

A transaction opens with START and the device address byte. A write continues with a sub-address byte, then any number of data bytes. In the sub-address byte, bits 6:0 load the register pointer and bit 7 turns on pointer auto-increment. A read first sets the pointer with a write-direction address byte and a sub-address byte. It then issues a repeated START and the read-direction address byte, after which the slave shifts out bytes starting at the stored pointer. SDA is driven open-drain: the block can only pull the line low or release it.

The controller is one state machine with these states:
- ST_IDLE: waits for START.
- ST_DEV and ST_DEV_ACK: receive and acknowledge the address byte.
- ST_SUB and ST_SUB_ACK: receive and acknowledge the sub-address.
- ST_WR and ST_WR_ACK: receive, write and acknowledge each data byte.
- ST_RD and ST_RD_ACK: shift out a byte, then sample the master's acknowledge.

Transitions:
- START in any state goes to ST_DEV. STOP in any state goes to ST_IDLE.
- At the SCL fall after the eighth received bit:
  - ST_DEV goes to ST_DEV_ACK on an address match, or to ST_IDLE on a mismatch.
  - ST_SUB goes to ST_SUB_ACK.
  - ST_WR goes to ST_WR_ACK.
- At the SCL fall that ends the ninth clock:
  - ST_DEV_ACK goes to ST_RD for a read or ST_SUB for a write.
  - ST_SUB_ACK and ST_WR_ACK go to ST_WR.
  - ST_RD_ACK goes to ST_RD on a master ACK, or ST_IDLE on a NACK.
- ST_RD goes to ST_RD_ACK at the SCL fall that ends its eighth bit.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, SDA is released (sda_drive_low = 0), reg_we and reg_re are 0, and the register pointer is 0x00.
- R2: SDA falling while SCL is high (START, also used as repeated START) begins reception of an address byte from any state. SDA rising while SCL is high (STOP) returns the block to idle with SDA released.
- R3: An address byte whose upper seven bits equal 0011101 is acknowledged by pulling SDA low through the ninth clock. Bit 0 of that byte selects the direction: 1 is read, 0 is write. On any other address the block never pulls SDA low and ignores all bytes until the next START.
- R4: The first byte after a write-direction address is the sub-address. Its bits 6:0 load the register pointer and its bit 7 sets (1) or clears (0) auto-increment. The sub-address byte is acknowledged.
- R5: Each later data byte is received MSB first, acknowledged, and written with a single-cycle reg_we at reg_addr equal to the pointer. reg_we and reg_re are never high in the same cycle.
- R6: With auto-increment set, the pointer advances by one after each written byte. With it clear, every byte of the burst goes to the same register.
- R7: Auto-increment wraps the pointer from 0x7F to 0x00.
- R8: After a repeated START and a read-direction address, the slave drives bytes MSB first starting at the stored pointer, with a single-cycle reg_re as each byte is fetched. A master ACK makes it send the next byte, from pointer+1 when auto-increment is set and from the same register otherwise.
- R9: After a master NACK the slave releases SDA and drives nothing more until the next START.
- R10: A START or STOP in the middle of a byte abandons that byte without a write and restarts bit counting, so a following transaction works normally.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 7 | Register file address (the pointer) |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe (byte fetched) |
| reg_rdata | input | 8 | Register file read data at reg_addr |

## Verification
The block sees a bus edge only after its two synchronizer flops and the edge register. Its SDA drive, pointer and strobes therefore change on the third rising system clock after the SCL or SDA pin moves. The bench leaves eight system clocks between any bus-line change and the next SCL edge. It samples SDA in the middle of the SCL high phase, so every acknowledge and data bit it reads was settled well before. Register contents are checked only after the STOP that ends each transaction, by which time every write strobe has landed in the bench's register model.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } link_state_t;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_rf_events.sv
module i2c_rf_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        bus_start = scl_s & scl_q & sda_q & ~sda_s;
        bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_rf_pointer.sv
module i2c_rf_pointer #(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             load_auto,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output logic             auto_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            auto_en <= 1'b0;
        end else if (load) begin
            ptr     <= load_val;
            auto_en <= load_auto;
        end else if (step && auto_en) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [PTR_W-1:0] DEV_ADDR    = 7'b0011101,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [1:0] lines_s;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    i2c_rf_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2c_rf_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    link_state_t        state, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg;
    logic               rw_bit;
    logic               ack_seen;
    logic               byte_in, last_out, receiving;
    logic               ptr_load, ptr_step, auto_en;
    logic [PTR_W-1:0]   ptr;

    assign byte_in   = (cnt == CNT_FULL);
    assign last_out  = (cnt == CNT_LAST);
    assign receiving = (state == ST_DEV) || (state == ST_SUB) || (state == ST_WR);

    i2c_rf_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(ptr_load), .load_val(shreg[PTR_W-1:0]), .load_auto(shreg[BYTE_W-1]),
        .step(ptr_step), .ptr(ptr), .auto_en(auto_en)
    );

    assign ptr_load = (state == ST_SUB) && scl_fall && byte_in;
    assign ptr_step = ((state == ST_WR_ACK) && scl_fall)
                    || ((state == ST_RD_ACK) && scl_rise && !sda_s);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = ST_IDLE;
            ST_DEV:     if (scl_fall && byte_in)
                            nxt = (shreg[BYTE_W-1:1] == DEV_ADDR) ? ST_DEV_ACK : ST_IDLE;
            ST_DEV_ACK: if (scl_fall) nxt = rw_bit ? ST_RD : ST_SUB;
            ST_SUB:     if (scl_fall && byte_in) nxt = ST_SUB_ACK;
            ST_SUB_ACK: if (scl_fall) nxt = ST_WR;
            ST_WR:      if (scl_fall && byte_in) nxt = ST_WR_ACK;
            ST_WR_ACK:  if (scl_fall) nxt = ST_WR;
            ST_RD:      if (scl_fall && last_out) nxt = ST_RD_ACK;
            ST_RD_ACK:  if (scl_fall) nxt = ack_seen ? ST_RD : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        if (bus_start)     nxt = ST_DEV;
        else if (bus_stop) nxt = ST_IDLE;
    end

    // byte datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            rw_bit   <= 1'b0;
            ack_seen <= 1'b0;
            reg_we   <= 1'b0;
            reg_re   <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (bus_start || bus_stop) begin
                cnt <= '0;
            end else begin
                if (receiving && scl_rise && !byte_in) begin
                    shreg <= {shreg[BYTE_W-2:0], sda_s};
                    cnt   <= cnt + 1'b1;
                end
                if ((state == ST_DEV) && scl_fall && byte_in)
                    rw_bit <= shreg[0];
                if ((state == ST_WR) && scl_fall && byte_in)
                    reg_we <= 1'b1;
                if (((state == ST_DEV_ACK) || (state == ST_SUB_ACK) || (state == ST_WR_ACK))
                    && scl_fall)
                    cnt <= '0;
                if (((state == ST_DEV_ACK) && scl_fall && rw_bit)
                    || ((state == ST_RD_ACK) && scl_fall && ack_seen)) begin
                    shreg  <= reg_rdata;
                    cnt    <= '0;
                    reg_re <= 1'b1;
                end
                if ((state == ST_RD) && scl_fall && !last_out) begin
                    shreg <= {shreg[BYTE_W-2:0], 1'b1};
                    cnt   <= cnt + 1'b1;
                end
                if ((state == ST_RD_ACK) && scl_rise)
                    ack_seen <= !sda_s;
            end
        end
    end

    // outputs
    always_comb begin
        sda_drive_low = (state == ST_DEV_ACK) || (state == ST_SUB_ACK) || (state == ST_WR_ACK)
                      || ((state == ST_RD) && !shreg[BYTE_W-1]);
        reg_addr  = ptr;
        reg_wdata = shreg;
    end
endmodule

// File: rtl/i2c_regfile_slave_checks.sv
module i2c_regfile_slave_checks (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic bus_start,
    input logic bus_stop,
    input logic sda_drive_low,
    input logic reg_we,
    input logic reg_re
);
    assert_release_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !sda_drive_low);

    assert_release_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_drive_low);

    assert_we_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, reg_re}));

    assert_re_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    assert_drive_only_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_s);
endmodule

bind i2c_regfile_slave i2c_regfile_slave_checks u_checks (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .bus_start(bus_start), .bus_stop(bus_stop),
    .sda_drive_low(sda_drive_low), .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/i2c_regfile_slave_test.sv
module i2c_regfile_slave_test;
    localparam int Q = 8;
    localparam logic [6:0] DEV = 7'b0011101;
    // {sub, d0, d1, addr0, final0, addr1, final1}
    localparam logic [55:0] VEC [4] = '{
        56'h10_A5_3C_10_3C_10_3C,
        56'hA0_11_22_20_11_21_22,
        56'hFF_5A_C3_7F_5A_00_C3,
        56'h81_E7_18_01_E7_02_18
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line, sda_drive_low, reg_we, reg_re;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [128];
    int checks = 0, errors = 0, we_count = 0, viol = 0;
    logic drv_q = 1'b0, scl_q = 1'b1;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    i2c_regfile_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_drive_low(sda_drive_low), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_count <= we_count + 1;
        end
        if (rst_n && scl_m && scl_q && (sda_drive_low !== drv_q)) viol <= viol + 1;
        drv_q <= sda_drive_low;
        scl_q <= scl_m;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b; w(Q); scl_m = 1'b1; w(Q); seen = sda_line; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        send_bits(b, 8);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(nack, s);
    endtask

    task automatic read2(input logic [7:0] sub, output logic a, output logic [7:0] d0, d1);
        logic x;
        bus_start(); send_byte({DEV, 1'b0}, x); send_byte(sub, x);
        bus_start(); send_byte({DEV, 1'b1}, a);
        recv_byte(1'b0, d0); recv_byte(1'b1, d1); bus_stop();
    endtask

    initial begin
        logic a1, a2, a3, a4;
        logic [7:0] d0, d1, d2;
        int wc;
        for (int i = 0; i < 128; i++) mem[i] = 8'h00;
        w(5);
        // R1 reset state
        chk("R1 sda released", sda_drive_low, 0);
        chk("R1 reg_we low", reg_we, 0);
        chk("R1 reg_re low", reg_re, 0);
        rst_n = 1'b1;
        w(4);
        chk("R1 pointer zero", reg_addr, 0);

        // vector table: write burst then read back
        for (int v = 0; v < 4; v++) begin
            bus_start();
            send_byte({DEV, 1'b0}, a1);
            send_byte(VEC[v][55:48], a2);
            send_byte(VEC[v][47:40], a3);
            send_byte(VEC[v][39:32], a4);
            bus_stop();
            chk("R3 address ack", a1, 1);
            chk("R4 sub-address ack", a2, 1);
            chk("R5 data acks", {a3, a4}, 2'b11);
            chk("R5/R6/R7 first register", mem[VEC[v][30:24]], VEC[v][23:16]);
            chk("R5/R6/R7 second register", mem[VEC[v][14:8]], VEC[v][7:0]);
            read2(VEC[v][55:48], a1, d0, d1);
            chk("R8 read address ack", a1, 1);
            chk("R8 first read byte", d0, VEC[v][23:16]);
            chk("R8 second read byte", d1, VEC[v][7:0]);
        end

        // R3 address mismatch: no ack, later bytes ignored
        wc = we_count;
        bus_start();
        send_byte({7'b0011100, 1'b0}, a1);
        send_byte(8'h85, a2);
        send_byte(8'h99, a3);
        bus_stop();
        chk("R3 mismatch no ack", {a1, a2, a3}, 0);
        chk("R3 mismatch no write", we_count, wc);
        chk("R3 mismatch register intact", mem[5], 8'h00);
        bus_start();
        send_byte({7'b1011101, 1'b1}, a1);
        recv_byte(1'b0, d0);
        bus_stop();
        chk("R3 mismatch read no drive", {a1, d0}, 9'h0FF);

        // R9 NACK ends the read
        bus_start(); send_byte({DEV, 1'b0}, a1); send_byte(8'h80 | 8'h20, a1);
        bus_start(); send_byte({DEV, 1'b1}, a1);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bus_stop();
        chk("R9 byte before nack", d0, 8'h11);
        chk("R9 released after nack", d1, 8'hFF);

        // R10 STOP mid-byte, then a normal write
        wc = we_count;
        bus_start(); send_byte({DEV, 1'b0}, a1); send_byte(8'h30, a1);
        send_bits(8'hF0, 4);
        bus_stop();
        chk("R10 stop mid-byte no write", we_count, wc);
        bus_start(); send_byte({DEV, 1'b0}, a1); send_byte(8'h31, a2);
        send_byte(8'h6B, a3); bus_stop();
        chk("R10 recovery acks", {a1, a2, a3}, 3'b111);
        chk("R10 recovery write", mem[8'h31], 8'h6B);
        chk("R10 aborted register intact", mem[8'h30], 8'h00);

        // R10 repeated START mid-byte, then new address byte
        wc = we_count;
        bus_start(); send_byte({DEV, 1'b0}, a1); send_byte(8'h40, a1);
        send_bits(8'hAA, 3);
        bus_start(); send_byte({DEV, 1'b0}, a1);
        chk("R10 start mid-byte address ack", a1, 1);
        chk("R10 start mid-byte no write", we_count, wc);
        send_byte(8'h41, a1); send_byte(8'h77, a1); bus_stop();
        chk("R10 write after restart", mem[8'h41], 8'h77);

        // R6 fixed pointer on read: repeated bytes from one register
        bus_start(); send_byte({DEV, 1'b0}, a1); send_byte(8'h41, a1);
        bus_start(); send_byte({DEV, 1'b1}, a1);
        recv_byte(1'b0, d0); recv_byte(1'b0, d1); recv_byte(1'b1, d2); bus_stop();
        chk("R6/R8 fixed pointer read", {d0, d1, d2}, 24'h777777);

        // R7 wrap on read
        bus_start(); send_byte({DEV, 1'b0}, a1); send_byte(8'hFF, a1);
        bus_start(); send_byte({DEV, 1'b1}, a1);
        recv_byte(1'b0, d0); recv_byte(1'b1, d1); bus_stop();
        chk("R7 read wrap", {d0, d1}, 16'h5AC3);

        w(20);
        chk("R11 drive stable while SCL high", viol, 0);
        chk("R2 idle after stop", sda_drive_low, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule